// File: doc/BRIEF.md
# Four-Entry Receive Holding Queue

This block holds received bytes between a serial receiver and a register interface. It stores up to four bytes in arrival order. It tells the receiver whether it can take another byte. It drives the two status bits that the register logic reports: data available and queue full. A read strobe from the data register removes the oldest byte. That byte is shown combinationally on the read port during the cycle of the strobe.

A line-break event is stored as a zero byte and sets a sticky break-change flag. The flag stays set until it is acknowledged. A break is never lost. When the queue already holds four bytes, the break byte replaces the newest entry. The receiver-reset command empties the queue in one cycle.

Top module: `rx_hold_fifo`

## Requirements
- R1: `data_avail` is 1 exactly when at least one byte is held, and `q_full` is 1 exactly when four bytes are held; both are 0 after reset.
- R2: `take_ok` equals `rx_on` AND NOT `q_full`; a data push (`in_valid`) presented while `take_ok` is 0 is dropped and changes no output.
- R3: A `brk_evt` pulse stores the byte 0x00 whatever `rx_on` and `q_full` are, and sets `brk_flag` one cycle later; in the same cycle it takes precedence over a data push, whose byte is dropped. `brk_ack` clears `brk_flag` unless a break arrives in the same cycle.
- R4: A break arriving while four bytes are held and no read is taken overwrites the newest entry; the count stays at four and the three older bytes keep their order.
- R5: With the queue empty, `rd_data` is 0x00 and a `rd_pop` strobe changes no state.
- R6: `rd_data` shows the oldest held byte; `rd_pop` removes it, so bytes leave in arrival order, and `q_full` is clear after a read from a full queue.
- R7: `flush` empties the queue on the next edge, clearing `data_avail` and `q_full`, and overrides any push or read in the same cycle.
- R8: When a read and an accepted push fall in the same cycle, the oldest byte is removed first and the new byte is appended, leaving the count unchanged; on a full queue this applies to a break push, which then overwrites nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_on | input | 1 | Receiver enabled level |
| in_valid | input | 1 | Received data byte offered this cycle |
| in_byte | input | 8 | Received data byte |
| brk_evt | input | 1 | Line-break event pulse |
| brk_ack | input | 1 | Clears the break-change flag |
| rd_pop | input | 1 | Data register read strobe |
| flush | input | 1 | Receiver-reset command |
| take_ok | output | 1 | Receiver may offer a byte |
| rd_data | output | 8 | Oldest byte, 0x00 when empty |
| data_avail | output | 1 | At least one byte held |
| q_full | output | 1 | Four bytes held |
| brk_flag | output | 1 | Sticky break-change flag |

## Verification
The assertions assume that all control inputs are synchronous to `clk` and stable across each rising edge. They also assume that `rd_pop`, `brk_evt` and `flush` are single-cycle strobes whose combinations are defined only by the priorities in R3, R7 and R8. The bench changes every input one time unit after a rising edge and keeps each strobe high for exactly one cycle. It creates the overlapping cases on purpose and within those priorities: a read together with a push, a break on a full queue, and a flush together with a push.

// File: rtl/rx_hold_fifo.sv
module rx_hold_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_on,
  input  logic          in_valid,
  input  logic [DW-1:0] in_byte,
  input  logic          brk_evt,
  input  logic          brk_ack,
  input  logic          rd_pop,
  input  logic          flush,
  output logic          take_ok,
  output logic [DW-1:0] rd_data,
  output logic          data_avail,
  output logic          q_full,
  output logic          brk_flag
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem   [DEPTH];
  logic [DW-1:0] mem_n [DEPTH];
  logic [CW-1:0] cnt, cnt_n, widx;
  logic          push_take, pop_take;
  logic [DW-1:0] push_byte;

  assign data_avail = (cnt != '0);
  assign q_full     = (cnt == CW'(DEPTH));
  assign take_ok    = rx_on & ~q_full;
  assign rd_data    = data_avail ? mem[0] : '0;

  assign push_take  = brk_evt | (in_valid & take_ok);
  assign push_byte  = brk_evt ? '0 : in_byte;
  assign pop_take   = rd_pop & data_avail;

  always_comb begin
    cnt_n = cnt;
    for (int i = 0; i < DEPTH; i++) mem_n[i] = mem[i];
    if (pop_take) begin
      for (int i = 0; i < DEPTH - 1; i++) mem_n[i] = mem[i+1];
      cnt_n = cnt - 1'b1;
    end
    widx = (cnt_n == CW'(DEPTH)) ? CW'(DEPTH - 1) : cnt_n;
    if (push_take) begin
      for (int i = 0; i < DEPTH; i++)
        if (widx == CW'(i)) mem_n[i] = push_byte;
      if (cnt_n != CW'(DEPTH)) cnt_n = cnt_n + 1'b1;
    end
    if (flush) cnt_n = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      cnt <= cnt_n;
      for (int i = 0; i < DEPTH; i++) mem[i] <= mem_n[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       brk_flag <= 1'b0;
    else if (brk_evt) brk_flag <= 1'b1;
    else if (brk_ack) brk_flag <= 1'b0;
  end

  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  assert_full_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !take_ok && !brk_evt && !rd_pop && !flush) |=> $stable(cnt));

  assert_brk_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |=> brk_flag);

  assert_brk_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (q_full && brk_evt && !rd_pop && !flush) |=> q_full);

  assert_empty_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_avail && rd_pop && !brk_evt && !in_valid && !flush) |=> !data_avail);

  assert_pop_dec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && data_avail && !brk_evt && !in_valid && !flush)
      |=> (cnt == $past(cnt) - 1'b1));

  assert_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!data_avail && !q_full));

  assert_pushpop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && data_avail && brk_evt && !flush) |=> $stable(cnt));
endmodule

// File: tb/rx_hold_fifo_tb.sv
module rx_hold_fifo_tb;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic rx_on = 0, in_valid = 0, brk_evt = 0, brk_ack = 0, rd_pop = 0, flush = 0;
  logic [7:0] in_byte = 0;
  logic take_ok, data_avail, q_full, brk_flag;
  logic [7:0] rd_data;
  int n_chk = 0, n_bad = 0;

  rx_hold_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .rx_on(rx_on), .in_valid(in_valid),
    .in_byte(in_byte), .brk_evt(brk_evt), .brk_ack(brk_ack),
    .rd_pop(rd_pop), .flush(flush), .take_ok(take_ok), .rd_data(rd_data),
    .data_avail(data_avail), .q_full(q_full), .brk_flag(brk_flag)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [7:0] b, input logic brk,
                      input logic pop, input logic fl, input logic ack);
    in_valid = v; in_byte = b; brk_evt = brk; rd_pop = pop; flush = fl; brk_ack = ack;
    @(posedge clk); #1;
    in_valid = 0; brk_evt = 0; rd_pop = 0; flush = 0; brk_ack = 0;
  endtask

  task automatic push(input logic [7:0] b); step(1, b, 0, 0, 0, 0); endtask

  task automatic pop_expect(input string req, input logic [7:0] exp);
    chk(req, rd_data, exp);
    step(0, 0, 0, 1, 0, 0);
  endtask

  task automatic clear_all;
    step(0, 0, 0, 0, 1, 1);
  endtask

  task automatic t_reset;
    chk("R1 reset avail", data_avail, 0);
    chk("R1 reset full", q_full, 0);
    chk("R3 reset brk_flag", brk_flag, 0);
    chk("R5 reset rd_data", rd_data, 8'h00);
    chk("R2 reset take_ok rx off", take_ok, 0);
  endtask

  task automatic t_fill_drain;
    rx_on = 1; #1;
    chk("R2 take_ok enabled empty", take_ok, 1);
    push(8'h11); push(8'h22); push(8'h33);
    chk("R1 three avail", data_avail, 1);
    chk("R1 three not full", q_full, 0);
    push(8'h44);
    chk("R1 four full", q_full, 1);
    chk("R2 full blocks take_ok", take_ok, 0);
    push(8'h55);
    chk("R2 dropped push keeps full", q_full, 1);
    pop_expect("R6 oldest first", 8'h11);
    chk("R6 read clears full", q_full, 0);
    pop_expect("R6 order 2", 8'h22);
    pop_expect("R6 order 3", 8'h33);
    pop_expect("R2 order 4 not 55", 8'h44);
    chk("R1 drained avail", data_avail, 0);
  endtask

  task automatic t_empty_read;
    step(0, 0, 0, 1, 0, 0);
    chk("R5 empty read avail", data_avail, 0);
    chk("R5 empty rd_data", rd_data, 8'h00);
    push(8'hAA);
    pop_expect("R5 state intact after empty read", 8'hAA);
    chk("R5 empty again", data_avail, 0);
  endtask

  task automatic t_disabled_drop;
    rx_on = 0; #1;
    chk("R2 take_ok rx off", take_ok, 0);
    push(8'h77);
    chk("R2 disabled push dropped", data_avail, 0);
  endtask

  task automatic t_break;
    rx_on = 0;
    step(1, 8'h99, 1, 0, 0, 0);
    chk("R3 brk sets flag", brk_flag, 1);
    chk("R3 brk stores byte", data_avail, 1);
    pop_expect("R3 brk byte zero, data dropped", 8'h00);
    chk("R3 single entry", data_avail, 0);
    step(0, 0, 1, 0, 0, 1);
    chk("R3 ack loses to brk", brk_flag, 1);
    step(0, 0, 0, 0, 0, 1);
    chk("R3 ack clears flag", brk_flag, 0);
    clear_all;
  endtask

  task automatic t_break_full;
    rx_on = 1;
    push(8'h01); push(8'h02); push(8'h03); push(8'h04);
    step(0, 0, 1, 0, 0, 0);
    chk("R4 count stays full", q_full, 1);
    pop_expect("R4 order 1", 8'h01);
    pop_expect("R4 order 2", 8'h02);
    pop_expect("R4 order 3", 8'h03);
    pop_expect("R4 newest overwritten", 8'h00);
    chk("R4 drained", data_avail, 0);
    clear_all;
  endtask

  task automatic t_same_cycle;
    rx_on = 1;
    push(8'h05); push(8'h06);
    chk("R8 rd_data before", rd_data, 8'h05);
    step(1, 8'h07, 0, 1, 0, 0);
    pop_expect("R8 next after pushpop", 8'h06);
    pop_expect("R8 appended byte", 8'h07);
    chk("R8 count unchanged, now empty", data_avail, 0);
    push(8'hA1); push(8'hA2); push(8'hA3); push(8'hA4);
    step(0, 0, 1, 1, 0, 0);
    chk("R8 full pop+brk stays full", q_full, 1);
    pop_expect("R8 full order 1", 8'hA2);
    pop_expect("R8 full order 2", 8'hA3);
    pop_expect("R8 full kept newest", 8'hA4);
    pop_expect("R8 brk appended", 8'h00);
    clear_all;
  endtask

  task automatic t_flush;
    rx_on = 1;
    push(8'h31); push(8'h32); push(8'h33);
    step(1, 8'h34, 0, 1, 1, 0);
    chk("R7 flush empties", data_avail, 0);
    chk("R7 flush full clear", q_full, 0);
    chk("R7 flush rd_data", rd_data, 8'h00);
    chk("R7 take_ok after flush", take_ok, 1);
  endtask

  initial begin
    #(CLK_P * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 2 + 1);
    t_reset;
    rst_n = 1;
    @(posedge clk); #1;
    t_reset;
    t_fill_drain;
    t_empty_read;
    t_disabled_drop;
    t_break;
    t_break_full;
    t_same_cycle;
    t_flush;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule